// File: doc/BRIEF.md
# Dual-Channel Capture and Replay Sequencer

This block sequences a two-input, two-output sampling system around a byte-addressed sample memory that is split into four equal regions. In capture mode it takes 8-bit samples from one of two input channels, once per sample tick, and writes them to consecutive locations of a chosen region. It captures one full region and then stops. In replay mode it reads the same offset from two chosen regions on every tick and loads both 8-bit output registers in one cycle, so the two waveforms stay aligned. It loops over the regions until a stop request arrives, and it honours the stop only when a region ends.

The sample tick comes from an internal divider. The divider offers nine rates and always uses the rate code present at that moment. An oscilloscope trigger output idles low. It pulses high for a few cycles when replay passes a programmable offset, which gives a clean falling edge. Memory is reached through a simple request/acknowledge port. The serial memory engine, the converters and any user interface sit outside this block.

Top module: `capture_replay_seq`

## Requirements
- R1: The memory address is the region code (0..3) in the top two address bits, above the offset within the region (0..REGION_WORDS-1). A request and its address stay unchanged until it is acknowledged.
- R2: The block issues no memory request until a capture or replay start is accepted. A capture start (`capSel` 0 = channel A, 1 = channel B) writes the chosen channel once per tick to offsets 0 through the last offset of the chosen region. Then `busy` drops and requests stop.
- R3: The tick period is TICK_BASE × {30, 25, 20, 15, 12, 10, 6, 5, 4} clock cycles for `rateSel` codes 0..8. Codes 9..15 use the code-0 period. The code is read live, so replay runs at the current rate.
- R4: On each replay tick the block reads offset k of region A, then offset k of region B. `outA` and `outB` load in the same cycle, in the cycle after the B read is acknowledged.
- R5: Replay wraps from the last offset back to 0 and repeats. A stop request ends replay only after the last offset of the current pass, and `busy` is low in the cycle after that load.
- R6: `trigOut` is low except for exactly TRIG_LEN cycles. Those cycles start right after an output load whose offset equals the stored trigger offset.
- R7: A trigger-offset write of REGION_WORDS or more is rejected. `trigErr` is high for one cycle after the write, and the old offset stays in force. A value below that limit is stored and `trigErr` stays low.
- R8: An output whose enable (`playEnA`/`playEnB`, sampled at replay start) is low keeps its previous value for the whole replay.
- R9: A tick that arrives while a memory access is still pending sets `overrun`. The flag stays set until the next accepted start clears it.
- R10: After reset, `outA`, `outB`, `trigOut`, `memReq`, `busy`, `overrun` and `trigErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rateSel | input | 4 | Sample-rate code |
| capStart | input | 1 | Capture start request (pulse) |
| capSel | input | 1 | Capture channel: 0 = A, 1 = B |
| capRegion | input | 2 | Capture target region |
| playStart | input | 1 | Replay start request (pulse) |
| playStop | input | 1 | Replay stop request (pulse) |
| playRegA | input | 2 | Region replayed on output A |
| playRegB | input | 2 | Region replayed on output B |
| playEnA | input | 1 | Output A enable for replay |
| playEnB | input | 1 | Output B enable for replay |
| trigWrEn | input | 1 | Trigger offset write strobe |
| trigWrData | input | CFG_W | Trigger offset write value |
| chanA | input | 8 | Input channel A sample |
| chanB | input | 8 | Input channel B sample |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | OFF_W+2 | Memory byte address |
| memWData | output | 8 | Memory write data |
| memAck | input | 1 | Memory acknowledge |
| memRData | input | 8 | Memory read data, valid with acknowledge |
| outA | output | 8 | Output register A |
| outB | output | 8 | Output register B |
| trigOut | output | 1 | Scope trigger pulse |
| trigErr | output | 1 | Rejected trigger write flag |
| busy | output | 1 | Capture or replay in progress |
| overrun | output | 1 | Sticky tick overrun flag |

## Verification
The bench times the spacing between memory accesses, both for a rate code above 8 and for a rate changed between capture and replay. A divider that fell back to the wrong period, or one that latched the rate used at capture, would show the wrong spacing. Stop requests arrive early in a pass and also in the second pass. A block that stopped at once would leave `busy` low early and skip offsets, and one that ignored the stop would keep issuing reads. The trigger offset is tested at a mid-region offset, at the last offset, and after a rejected write. A bad offset check would move the pulse or leave the error flag silent. The memory acknowledge is stalled across two ticks: a missing overrun flag, or one that clears itself, fails the check at the ports.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAP_WAIT,
    ST_CAP_WR,
    ST_PLAY_WAIT,
    ST_PLAY_RDA,
    ST_PLAY_RDB
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capCfg;   // latch capture settings
    logic playCfg;  // latch replay settings
    logic offClr;   // reset offset to 0
    logic offInc;   // advance offset
    logic sample;   // take a channel sample
    logic selB;     // address region B
    logic latchA;   // hold read data A
    logic loadOut;  // load both output registers
  } seqStrobe_t;

  // tick period multiplier per rate code; out-of-range codes use the slowest
  function automatic int unsigned rateMult(input logic [3:0] code);
    case (code)
      4'd0:    return 30;
      4'd1:    return 25;
      4'd2:    return 20;
      4'd3:    return 15;
      4'd4:    return 12;
      4'd5:    return 10;
      4'd6:    return 6;
      4'd7:    return 5;
      4'd8:    return 4;
      default: return 30;
    endcase
  endfunction

endpackage

// File: rtl/seq_tick.sv
module seq_tick #(
  parameter int unsigned TICK_BASE = 400,
  parameter int unsigned CNT_W     = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic [3:0] rateSel,
  output logic       tick
);
  import seq_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] divVal;

  assign divVal = CNT_W'(TICK_BASE * rateMult(rateSel));
  // ">=" lets a rate change to a shorter period take effect at once
  assign tick   = en && (cnt >= divVal - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                  cnt <= cnt + CNT_W'(1);
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R3

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                capStart,
  input  logic                playStart,
  input  logic                playStop,
  input  logic                tick,
  input  logic                memAck,
  input  logic                offLast,
  output seq_pkg::seqStrobe_t strobe,
  output logic                memReq,
  output logic                memWe,
  output logic                busy,
  output logic                overrun
);
  import seq_pkg::*;

  seqState_t state, stateNext;
  logic      stopPend;
  logic      startTaken;
  logic      accessPending;

  assign startTaken    = (state == ST_IDLE) && (capStart || playStart);
  assign accessPending = (state == ST_CAP_WR) || (state == ST_PLAY_RDA) ||
                         (state == ST_PLAY_RDB);
  assign busy          = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (capStart) begin
          strobe.capCfg = 1'b1;
          strobe.offClr = 1'b1;
          stateNext     = ST_CAP_WAIT;
        end else if (playStart) begin
          strobe.playCfg = 1'b1;
          strobe.offClr  = 1'b1;
          stateNext      = ST_PLAY_WAIT;
        end
      end
      ST_CAP_WAIT: begin
        if (tick) begin
          strobe.sample = 1'b1;
          stateNext     = ST_CAP_WR;
        end
      end
      ST_CAP_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          strobe.offInc = 1'b1;
          stateNext     = offLast ? ST_IDLE : ST_CAP_WAIT;
        end
      end
      ST_PLAY_WAIT: begin
        if (tick) stateNext = ST_PLAY_RDA;
      end
      ST_PLAY_RDA: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.latchA = 1'b1;
          stateNext     = ST_PLAY_RDB;
        end
      end
      ST_PLAY_RDB: begin
        memReq      = 1'b1;
        strobe.selB = 1'b1;
        if (memAck) begin
          strobe.loadOut = 1'b1;
          strobe.offInc  = 1'b1;
          stateNext = (offLast && (stopPend || playStop)) ? ST_IDLE : ST_PLAY_WAIT;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stopPend <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      state <= stateNext;
      if (startTaken)                     stopPend <= 1'b0;
      else if (playStop && busy)          stopPend <= 1'b1;
      if (startTaken)                     overrun  <= 1'b0;
      else if (tick && accessPending)     overrun  <= 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !memReq); // R2
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !startTaken) |=> overrun); // R9
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (tick && memReq && !memAck && !startTaken) |=> overrun); // R9

endmodule

// File: rtl/seq_dpath.sv
module seq_dpath #(
  parameter int unsigned OFF_W    = 13,
  parameter int unsigned CFG_W    = 16,
  parameter int unsigned TRIG_LEN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_pkg::seqStrobe_t strobe,
  input  logic                capSel,
  input  logic [1:0]          capRegion,
  input  logic [1:0]          playRegA,
  input  logic [1:0]          playRegB,
  input  logic                playEnA,
  input  logic                playEnB,
  input  logic [7:0]          chanA,
  input  logic [7:0]          chanB,
  input  logic [7:0]          memRData,
  input  logic                trigWrEn,
  input  logic [CFG_W-1:0]    trigWrData,
  output logic [OFF_W+1:0]    memAddr,
  output logic [7:0]          memWData,
  output logic                offLast,
  output logic [7:0]          outA,
  output logic [7:0]          outB,
  output logic                trigOut,
  output logic                trigErr
);
  import seq_pkg::*;

  localparam int unsigned REGION_WORDS = 1 << OFF_W;
  localparam int unsigned TC_W         = $clog2(TRIG_LEN + 1);

  logic             modeCap;
  logic             capSelR;
  logic [1:0]       capRegR, regAR, regBR;
  logic             enAR, enBR;
  logic [OFF_W-1:0] off;
  logic [7:0]       wdata, holdA;
  logic [OFF_W-1:0] trigOff;
  logic [TC_W-1:0]  trigCnt;
  logic [1:0]       region;
  logic             trigBad;

  assign region   = modeCap ? capRegR : (strobe.selB ? regBR : regAR);
  assign memAddr  = {region, off};
  assign memWData = wdata;
  assign offLast  = &off;
  assign trigOut  = (trigCnt != '0);
  assign trigBad  = (trigWrData >= CFG_W'(REGION_WORDS));

  // configuration latched at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeCap <= 1'b0;
      capSelR <= 1'b0;
      capRegR <= '0;
      regAR   <= '0;
      regBR   <= '0;
      enAR    <= 1'b0;
      enBR    <= 1'b0;
    end else if (strobe.capCfg) begin
      modeCap <= 1'b1;
      capSelR <= capSel;
      capRegR <= capRegion;
    end else if (strobe.playCfg) begin
      modeCap <= 1'b0;
      regAR   <= playRegA;
      regBR   <= playRegB;
      enAR    <= playEnA;
      enBR    <= playEnB;
    end
  end

  // offset, sample and read data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      off   <= '0;
      wdata <= '0;
      holdA <= '0;
      outA  <= '0;
      outB  <= '0;
    end else begin
      if (strobe.offClr)      off <= '0;
      else if (strobe.offInc) off <= off + OFF_W'(1);
      if (strobe.sample)      wdata <= capSelR ? chanB : chanA;
      if (strobe.latchA)      holdA <= memRData;
      if (strobe.loadOut) begin
        if (enAR) outA <= holdA;
        if (enBR) outB <= memRData;
      end
    end
  end

  // trigger offset register and pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigOff <= '0;
      trigErr <= 1'b0;
      trigCnt <= '0;
    end else begin
      trigErr <= trigWrEn && trigBad;
      if (trigWrEn && !trigBad) trigOff <= trigWrData[OFF_W-1:0];
      if (strobe.loadOut && (off == trigOff)) trigCnt <= TC_W'(TRIG_LEN);
      else if (trigCnt != '0)                 trigCnt <= trigCnt - TC_W'(1);
    end
  end

  AST_TRIG_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigOut) |-> $past(strobe.loadOut)); // R6
  AST_TRIG_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (trigWrEn && trigBad) |=> (trigErr && $stable(trigOff))); // R7
  AST_OUT_A_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadOut && enAR) |=> $stable(outA)); // R8
  AST_OUT_B_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadOut && enBR) |=> $stable(outB)); // R8

endmodule

// File: rtl/capture_replay_seq.sv
module capture_replay_seq #(
  parameter int unsigned OFF_W     = 13,
  parameter int unsigned CFG_W     = 16,
  parameter int unsigned TICK_BASE = 400,
  parameter int unsigned TRIG_LEN  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         rateSel,
  input  logic               capStart,
  input  logic               capSel,
  input  logic [1:0]         capRegion,
  input  logic               playStart,
  input  logic               playStop,
  input  logic [1:0]         playRegA,
  input  logic [1:0]         playRegB,
  input  logic               playEnA,
  input  logic               playEnB,
  input  logic               trigWrEn,
  input  logic [CFG_W-1:0]   trigWrData,
  input  logic [7:0]         chanA,
  input  logic [7:0]         chanB,
  output logic               memReq,
  output logic               memWe,
  output logic [OFF_W+1:0]   memAddr,
  output logic [7:0]         memWData,
  input  logic               memAck,
  input  logic [7:0]         memRData,
  output logic [7:0]         outA,
  output logic [7:0]         outB,
  output logic               trigOut,
  output logic               trigErr,
  output logic               busy,
  output logic               overrun
);
  import seq_pkg::*;

  localparam int unsigned CNT_W = $clog2(TICK_BASE * 30 + 1);

  seqStrobe_t strobe;
  logic       tick;
  logic       offLast;

  seq_tick #(.TICK_BASE(TICK_BASE), .CNT_W(CNT_W)) u_tick (
    .clk(clk), .rstN(rstN), .en(busy), .rateSel(rateSel), .tick(tick)
  );

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .capStart(capStart), .playStart(playStart),
    .playStop(playStop), .tick(tick), .memAck(memAck), .offLast(offLast),
    .strobe(strobe), .memReq(memReq), .memWe(memWe), .busy(busy),
    .overrun(overrun)
  );

  seq_dpath #(.OFF_W(OFF_W), .CFG_W(CFG_W), .TRIG_LEN(TRIG_LEN)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .capSel(capSel),
    .capRegion(capRegion), .playRegA(playRegA), .playRegB(playRegB),
    .playEnA(playEnA), .playEnB(playEnB), .chanA(chanA), .chanB(chanB),
    .memRData(memRData), .trigWrEn(trigWrEn), .trigWrData(trigWrData),
    .memAddr(memAddr), .memWData(memWData), .offLast(offLast),
    .outA(outA), .outB(outB), .trigOut(trigOut), .trigErr(trigErr)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R1

endmodule

// File: tb/capture_replay_seq_bench.sv
module capture_replay_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int OFF_W      = 4;
  localparam int NW         = 1 << OFF_W;
  localparam int BASE       = 2;
  localparam int TLEN       = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [3:0]       rateSel = '0;
  logic             capStart = 1'b0, capSel = 1'b0;
  logic [1:0]       capRegion = '0;
  logic             playStart = 1'b0, playStop = 1'b0;
  logic [1:0]       playRegA = '0, playRegB = '0;
  logic             playEnA = 1'b0, playEnB = 1'b0;
  logic             trigWrEn = 1'b0;
  logic [15:0]      trigWrData = '0;
  logic [7:0]       chanA = '0, chanB = '0;
  logic             memReq, memWe, memAck;
  logic [OFF_W+1:0] memAddr;
  logic [7:0]       memWData, memRData;
  logic [7:0]       outA, outB;
  logic             trigOut, trigErr, busy, overrun;
  logic             stall = 1'b0;

  logic [7:0] mem [0:4*NW-1];
  int         cyc = 0;
  int         nChk = 0, nBad = 0;
  int         trigExp = 0;
  logic [7:0] lastA = '0, lastB = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign memAck   = memReq && !stall;
  assign memRData = mem[memAddr];
  always @(posedge clk) if (memReq && memWe && memAck) mem[memAddr] <= memWData;

  capture_replay_seq #(.OFF_W(OFF_W), .CFG_W(16), .TICK_BASE(BASE), .TRIG_LEN(TLEN))
  u_capture_replay_seq (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .capStart(capStart), .capSel(capSel),
    .capRegion(capRegion), .playStart(playStart), .playStop(playStop),
    .playRegA(playRegA), .playRegB(playRegB), .playEnA(playEnA), .playEnB(playEnB),
    .trigWrEn(trigWrEn), .trigWrData(trigWrData), .chanA(chanA), .chanB(chanB),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memAck(memAck), .memRData(memRData), .outA(outA), .outB(outB),
    .trigOut(trigOut), .trigErr(trigErr), .busy(busy), .overrun(overrun)
  );

  function automatic int divOf(input int code);
    int m [9] = '{30, 25, 20, 15, 12, 10, 6, 5, 4};
    return (code > 8) ? BASE * 30 : BASE * m[code];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic quietFor(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (memReq) seen = 1;
    end
    chk(!seen && !busy, req, int'(seen), 0);
  endtask

  // R10 reset state, R2 no request before a start
  task automatic t_reset();
    for (int i = 0; i < 4*NW; i++) mem[i] = 8'(i) ^ 8'h3C;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(outA == 0 && outB == 0, "R10 outputs", {outA, outB}, 0);
    chk(!trigOut && !trigErr, "R10 trigger", {trigOut, trigErr}, 0);
    chk(!busy && !overrun && !memReq, "R10 status", {busy, overrun, memReq}, 0);
    quietFor(100, "R2 idle without start");
  endtask

  // R1 R2 R3: capture one region
  task automatic t_capture(input bit sel, input int region, input int rate);
    int prev = 0;
    int dv = divOf(rate);
    logic [7:0] start = sel ? 8'h80 : 8'h10;
    chanA = 8'h10; chanB = 8'h80;
    capSel = sel; capRegion = 2'(region); rateSel = 4'(rate);
    @(negedge clk); capStart = 1'b1;
    @(negedge clk); capStart = 1'b0;
    for (int k = 0; k < NW; k++) begin
      do @(negedge clk); while (!(memReq && memWe));
      chk(int'(memAddr) == region*NW + k, "R1 capture address", int'(memAddr), region*NW + k);
      chk(memWData == 8'(start + k), "R2 captured sample", memWData, 8'(start + k));
      if (k > 0) chk(cyc - prev == dv, "R3 capture tick period", cyc - prev, dv);
      prev = cyc;
      @(negedge clk);
      chanA = chanA + 8'd1; chanB = chanB + 8'd1;
      if (k == NW-1) chk(!busy, "R2 capture stops at region end", busy, 0);
    end
    quietFor(2*dv, "R2 no request after capture");
  endtask

  task automatic writeTrig(input int v);
    bit bad = (v >= NW);
    @(negedge clk); trigWrEn = 1'b1; trigWrData = 16'(v);
    @(negedge clk); trigWrEn = 1'b0;
    chk(trigErr == bad, "R7 trigger write flag", trigErr, int'(bad));
    @(negedge clk);
    chk(!trigErr, "R7 flag lasts one cycle", trigErr, 0);
    if (!bad) trigExp = v;
  endtask

  // R3 R4 R5 R6 R8: replay
  task automatic t_play(input int ra, input int rb, input bit ea, input bit eb,
                        input int rate, input int passes, input int stopK);
    int prev = 0;
    int dv = divOf(rate);
    playRegA = 2'(ra); playRegB = 2'(rb); playEnA = ea; playEnB = eb;
    rateSel = 4'(rate);
    @(negedge clk); playStart = 1'b1;
    @(negedge clk); playStart = 1'b0;
    chk(!overrun, "R9 overrun cleared by start", overrun, 0);
    for (int p = 0; p < passes; p++) begin
      for (int k = 0; k < NW; k++) begin
        do @(negedge clk); while (!(memReq && !memWe));
        chk(int'(memAddr) == ra*NW + k, "R4 R5 read A address", int'(memAddr), ra*NW + k);
        if (p > 0 || k > 0) chk(cyc - prev == dv, "R3 replay tick period", cyc - prev, dv);
        prev = cyc;
        @(negedge clk);
        chk(memReq && !memWe && int'(memAddr) == rb*NW + k, "R4 read B follows A",
            int'(memAddr), rb*NW + k);
        @(negedge clk);
        if (ea) lastA = mem[ra*NW + k];
        if (eb) lastB = mem[rb*NW + k];
        chk(outA == lastA, "R4 R8 outA", outA, lastA);
        chk(outB == lastB, "R4 R8 outB", outB, lastB);
        chk(trigOut == (k == trigExp), "R6 trigger at offset", trigOut, int'(k == trigExp));
        if (p == passes-1 && k == NW-1) chk(!busy, "R5 stop at region end", busy, 0);
        else chk(busy, "R5 still running", busy, 1);
        if (k == trigExp) begin
          repeat (TLEN-1) @(negedge clk);
          chk(trigOut, "R6 pulse length high", trigOut, 1);
          @(negedge clk);
          chk(!trigOut, "R6 pulse returns low", trigOut, 0);
        end
        if (p == passes-1 && k == stopK) begin
          playStop = 1'b1;
          @(negedge clk); playStop = 1'b0;
        end
      end
    end
    quietFor(2*dv, "R5 no read after stop");
  endtask

  // R9: overrun while memory stalls
  task automatic t_overrun();
    capSel = 1'b0; capRegion = 2'd0; rateSel = 4'd8;
    @(negedge clk); capStart = 1'b1;
    @(negedge clk); capStart = 1'b0; stall = 1'b1;
    repeat (3*divOf(8)) @(negedge clk);
    chk(overrun, "R9 overrun set on stalled tick", overrun, 1);
    stall = 1'b0;
    repeat (2*divOf(8)) @(negedge clk);
    chk(overrun, "R9 overrun is sticky", overrun, 1);
    while (busy) @(negedge clk);
    chk(overrun, "R9 overrun kept after capture", overrun, 1);
    t_play(2, 1, 1'b1, 1'b1, 8, 1, 0);
  endtask

  initial begin
    t_reset();
    t_capture(1'b0, 2, 8);
    t_capture(1'b1, 1, 13);
    writeTrig(7);
    t_play(2, 1, 1'b1, 1'b1, 8, 2, 3);
    writeTrig(NW);
    t_play(1, 2, 1'b1, 1'b0, 3, 1, 2);
    writeTrig(NW - 1);
    t_play(3, 0, 1'b1, 1'b1, 6, 1, 0);
    t_overrun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule